// File: doc/BRIEF.md
# Descriptor Cache Flush Sequencer

This block takes one flush command for a descriptor cache and carries it out step by step. A command arrives as three 32-bit beats on a valid/ready port. The sequencer may first ask a packet-forward engine to drain the queue that the descriptor describes. It then asks a cache-flush engine to write back one descriptor line, or the whole cache. It can also ask for a second flush of a companion descriptor that sits a fixed offset above the first one. Each engine request is a level that stays high until the engine returns a one-cycle done pulse.

Four blocking resources each hold a 40-bit address and a busy flag. A command can free one resource before it runs. It can also claim a resource after a successful flush, so that later accesses to that address are reported as blocked. A flush of the whole cache instead raises a cache-wide block. A separate unblock port lifts the cache-wide block or frees a single resource. A combinational lookup port reports whether an address is blocked. When the command asks for it, each command or unblock ends with a one-cycle status record that carries the command number and an error flag.

Top module: `dflush_seq`

## Requirements
- R1: A command is three beats accepted on `cmd_valid && cmd_ready`. Beat 0 holds the command number in [15:0] and the status-wanted flag in bit 16. Beat 1 holds address [31:0]. Beat 2 holds address [39:32] in [7:0], forward in bit 8, release in bit 9, resource index in [11:10], keep-valid in bit 12, block-after in bit 13, whole-cache in bit 14 and companion in bit 15. `cmd_ready` is low from the final beat until the sequence has finished.
- R2: With forward set, `fwd_req` is raised with the command address. No flush request is raised until `fwd_done` has been seen.
- R3: A line flush is requested at the 40-bit command address. `fl_inval` is 0 when keep-valid is set and 1 otherwise, and `fl_all` is 0.
- R4: With companion set, a second flush is requested at the command address plus `EXT_OFS`, after the done pulse of the first flush.
- R5: With release set, the indexed resource is freed before any request. If it was already free, the command ends with an error and makes no request.
- R6: With block-after set and the indexed resource still busy after the release step, the command ends with an error and makes no request. On success, block-after marks the resource busy with the command address.
- R7: Whole-cache issues a single flush with `fl_all`=1 and `fl_inval`=1. It ignores every other beat-2 field, leaves all four resources unchanged, and sets a cache-wide block.
- R8: `lk_blocked` follows `lk_addr` in the same cycle. It is 1 when the cache-wide block is on, or when a busy resource holds exactly `lk_addr`.
- R9: An unblock with `unblk_whole`=1 clears the cache-wide block. With `unblk_whole`=0 it frees resource `unblk_idx`, and it reports an error if that resource was already free.
- R10: `st_valid` pulses for one cycle only when status was asked for, with `st_num` and `st_err`. For a sequence with requests it comes in the cycle after the last done pulse. For a command that aborts it comes two cycles after the final beat, and for an unblock one cycle after acceptance.
- R11: After reset the sequencer is idle and ready, no request or status is raised, no resource is busy and nothing is blocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command beat valid |
| cmd_word | input | 32 | Command beat data |
| cmd_ready | output | 1 | Command beat accepted when high |
| unblk_valid | input | 1 | Unblock command valid |
| unblk_whole | input | 1 | 1: lift cache-wide block, 0: free one resource |
| unblk_idx | input | IDX_W | Resource to free |
| unblk_num | input | 16 | Unblock command number |
| unblk_stat_req | input | 1 | Status wanted for the unblock |
| unblk_ready | output | 1 | Unblock accepted when high |
| fwd_req | output | 1 | Forward request level |
| fwd_addr | output | 40 | Queue descriptor to drain |
| fwd_done | input | 1 | Forward engine done pulse |
| fl_req | output | 1 | Flush request level |
| fl_addr | output | 40 | Line to flush |
| fl_inval | output | 1 | Invalidate the line after writeback |
| fl_all | output | 1 | Flush the whole cache |
| fl_done | input | 1 | Flush engine done pulse |
| lk_addr | input | 40 | Lookup address |
| lk_blocked | output | 1 | Lookup address is blocked |
| st_valid | output | 1 | Status record valid |
| st_num | output | 16 | Command number echoed |
| st_err | output | 1 | Command ended with an error |

## Verification
Count from the edge that takes the final command beat. A command that proceeds shows its first request two cycles later, and one that aborts shows its status two cycles later. After that, every step is timed by the done pulse that closed the previous step, and the status comes one cycle after the last done pulse. An unblock reports one cycle after acceptance. The bench engine model logs each request with the cycle index at which it saw it. The bench then compares those indices against the counts above, and the order, addresses and flags against its own model of the four resources. Lookups are driven between edges and sampled one time step later in the same cycle.

// File: rtl/dflush_pkg.sv
package dflush_pkg;
    localparam int ADDR_W = 40;
    localparam int NUM_W  = 16;
    localparam int WORD_W = 32;

    typedef enum logic [2:0] {
        S_IDLE,
        S_EXEC,
        S_FWD,
        S_FLUSH,
        S_FLUSH_EXT,
        S_FIN
    } seq_state_e;
endpackage

// File: rtl/dflush_cmd_decode.sv
module dflush_cmd_decode
    import dflush_pkg::*;
#(
    parameter int IDX_W = 2
) (
    input  logic [WORD_W-1:0] word,
    output logic [NUM_W-1:0]  hdr_num,
    output logic              hdr_stat,
    output logic [7:0]        addr_hi,
    output logic              f_fwd,
    output logic              f_rel,
    output logic [IDX_W-1:0]  f_idx,
    output logic              f_keep,
    output logic              f_blk,
    output logic              f_all,
    output logic              f_ext
);
    // beat-0 view
    assign hdr_num  = word[NUM_W-1:0];
    assign hdr_stat = word[16];
    // beat-2 view
    assign addr_hi  = word[7:0];
    assign f_fwd    = word[8];
    assign f_rel    = word[9];
    assign f_idx    = word[10 +: IDX_W];
    assign f_keep   = word[12];
    assign f_blk    = word[13];
    assign f_all    = word[14];
    assign f_ext    = word[15];

    logic unused_bits;
    assign unused_bits = ^word[WORD_W-1:17];
endmodule

// File: rtl/dflush_blk_match.sv
module dflush_blk_match
    import dflush_pkg::*;
#(
    parameter int NUM_RES = 4
) (
    input  logic                             cache_blk,
    input  logic [NUM_RES-1:0]               busy,
    input  logic [NUM_RES-1:0][ADDR_W-1:0]   raddr,
    input  logic [ADDR_W-1:0]                lk_addr,
    output logic                             blocked
);
    logic [NUM_RES-1:0] hit;

    for (genvar g = 0; g < NUM_RES; g++) begin : g_cmp
        assign hit[g] = busy[g] && (raddr[g] == lk_addr);
    end

    assign blocked = cache_blk || (|hit);
endmodule

// File: rtl/dflush_seq.sv
module dflush_seq
    import dflush_pkg::*;
#(
    parameter int              NUM_RES = 4,
    parameter logic [39:0]     EXT_OFS = 40'h100,
    localparam int             IDX_W   = $clog2(NUM_RES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic [31:0]        cmd_word,
    output logic               cmd_ready,
    input  logic               unblk_valid,
    input  logic               unblk_whole,
    input  logic [IDX_W-1:0]   unblk_idx,
    input  logic [15:0]        unblk_num,
    input  logic               unblk_stat_req,
    output logic               unblk_ready,
    output logic               fwd_req,
    output logic [39:0]        fwd_addr,
    input  logic               fwd_done,
    output logic               fl_req,
    output logic [39:0]        fl_addr,
    output logic               fl_inval,
    output logic               fl_all,
    input  logic               fl_done,
    input  logic [39:0]        lk_addr,
    output logic               lk_blocked,
    output logic               st_valid,
    output logic [15:0]        st_num,
    output logic               st_err
);
    typedef struct packed {
        seq_state_e                         state;
        logic [1:0]                         beat;
        logic [NUM_W-1:0]                   num;
        logic                               stat_req;
        logic [ADDR_W-1:0]                  addr;
        logic                               fwd;
        logic                               rel;
        logic [IDX_W-1:0]                   idx;
        logic                               keep;
        logic                               blk;
        logic                               all;
        logic                               ext;
        logic                               err;
        logic                               cache_blk;
        logic [NUM_RES-1:0]                 busy;
        logic [NUM_RES-1:0][ADDR_W-1:0]     raddr;
    } seq_regs_t;

    seq_regs_t q, d;

    logic [NUM_W-1:0] dec_num;
    logic             dec_stat, dec_fwd, dec_rel, dec_keep, dec_blk, dec_all, dec_ext;
    logic [7:0]       dec_hi;
    logic [IDX_W-1:0] dec_idx;

    dflush_cmd_decode #(.IDX_W(IDX_W)) u_dec (
        .word    (cmd_word),
        .hdr_num (dec_num),
        .hdr_stat(dec_stat),
        .addr_hi (dec_hi),
        .f_fwd   (dec_fwd),
        .f_rel   (dec_rel),
        .f_idx   (dec_idx),
        .f_keep  (dec_keep),
        .f_blk   (dec_blk),
        .f_all   (dec_all),
        .f_ext   (dec_ext)
    );

    dflush_blk_match #(.NUM_RES(NUM_RES)) u_match (
        .cache_blk(q.cache_blk),
        .busy     (q.busy),
        .raddr    (q.raddr),
        .lk_addr  (lk_addr),
        .blocked  (lk_blocked)
    );

    logic idle;
    assign idle        = (q.state == S_IDLE);
    assign unblk_ready = idle && (q.beat == 2'd0);
    assign cmd_ready   = idle && !(unblk_valid && q.beat == 2'd0);

    always_comb begin
        d = q;
        unique case (q.state)
            S_IDLE: begin
                if (unblk_valid && unblk_ready) begin
                    d.num      = unblk_num;
                    d.stat_req = unblk_stat_req;
                    d.err      = 1'b0;
                    d.blk      = 1'b0;
                    d.all      = 1'b0;
                    if (unblk_whole) begin
                        d.cache_blk = 1'b0;
                    end else if (q.busy[unblk_idx]) begin
                        d.busy[unblk_idx] = 1'b0;
                    end else begin
                        d.err = 1'b1;
                    end
                    d.state = S_FIN;
                end else if (cmd_valid && cmd_ready) begin
                    unique case (q.beat)
                        2'd0: begin
                            d.num      = dec_num;
                            d.stat_req = dec_stat;
                            d.beat     = 2'd1;
                        end
                        2'd1: begin
                            d.addr[31:0] = cmd_word;
                            d.beat       = 2'd2;
                        end
                        default: begin
                            d.addr[39:32] = dec_hi;
                            d.fwd   = dec_fwd;
                            d.rel   = dec_rel;
                            d.idx   = dec_idx;
                            d.keep  = dec_keep;
                            d.blk   = dec_blk;
                            d.all   = dec_all;
                            d.ext   = dec_ext;
                            d.err   = 1'b0;
                            d.beat  = 2'd0;
                            d.state = S_EXEC;
                        end
                    endcase
                end
            end
            S_EXEC: begin
                if (q.all) begin
                    d.cache_blk = 1'b1;
                    d.state     = S_FLUSH;
                end else if (q.rel && !q.busy[q.idx]) begin
                    d.err   = 1'b1;
                    d.state = S_FIN;
                end else if (q.blk && q.busy[q.idx] && !q.rel) begin
                    d.err   = 1'b1;
                    d.state = S_FIN;
                end else begin
                    if (q.rel) begin
                        d.busy[q.idx] = 1'b0;
                    end
                    d.state = q.fwd ? S_FWD : S_FLUSH;
                end
            end
            S_FWD: begin
                if (fwd_done) begin
                    d.state = S_FLUSH;
                end
            end
            S_FLUSH: begin
                if (fl_done) begin
                    d.state = (q.ext && !q.all) ? S_FLUSH_EXT : S_FIN;
                end
            end
            S_FLUSH_EXT: begin
                if (fl_done) begin
                    d.state = S_FIN;
                end
            end
            default: begin
                if (!q.err && q.blk && !q.all) begin
                    d.busy[q.idx]  = 1'b1;
                    d.raddr[q.idx] = q.addr;
                end
                d.state = S_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign fwd_req  = (q.state == S_FWD);
    assign fwd_addr = q.addr;
    assign fl_req   = (q.state == S_FLUSH) || (q.state == S_FLUSH_EXT);
    assign fl_addr  = (q.state == S_FLUSH_EXT) ? (q.addr + EXT_OFS) : q.addr;
    assign fl_inval = q.all || !q.keep;
    assign fl_all   = q.all;
    assign st_valid = (q.state == S_FIN) && q.stat_req;
    assign st_num   = q.num;
    assign st_err   = q.err;
endmodule

// File: rtl/dflush_seq_chk.sv
module dflush_seq_chk #(
    parameter logic [39:0] EXT_OFS = 40'h100
) (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_ready,
    input logic        fwd_req,
    input logic        fwd_done,
    input logic        fl_req,
    input logic [39:0] fl_addr,
    input logic        fl_inval,
    input logic        fl_all,
    input logic        fl_done,
    input logic        st_valid
);
    assert_single_engine_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(fwd_req && fl_req));

    assert_busy_not_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_req || fl_req || st_valid) |-> !cmd_ready);

    assert_fwd_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_req && !fwd_done) |=> fwd_req);

    assert_flush_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_req && !fl_done) |=> (fl_req && $stable(fl_addr) && $stable(fl_inval)));

    assert_ext_offset_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_req && fl_done && !fl_all) |=> (!fl_req || fl_addr == $past(fl_addr) + EXT_OFS));

    assert_all_inval_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_req && fl_all) |-> fl_inval);

    assert_status_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid |=> !st_valid);
endmodule

bind dflush_seq dflush_seq_chk #(.EXT_OFS(EXT_OFS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_ready(cmd_ready),
    .fwd_req  (fwd_req),
    .fwd_done (fwd_done),
    .fl_req   (fl_req),
    .fl_addr  (fl_addr),
    .fl_inval (fl_inval),
    .fl_all   (fl_all),
    .fl_done  (fl_done),
    .st_valid (st_valid)
);

// File: tb/sim_dflush_seq.sv
`timescale 1ns/1ps
module sim_dflush_seq;
    localparam logic [39:0] EXT = 40'h100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [31:0] cmd_word = '0;
    logic        cmd_ready;
    logic        unblk_valid = 1'b0;
    logic        unblk_whole = 1'b0;
    logic [1:0]  unblk_idx = '0;
    logic [15:0] unblk_num = '0;
    logic        unblk_stat_req = 1'b0;
    logic        unblk_ready;
    logic        fwd_req;
    logic [39:0] fwd_addr;
    logic        fwd_done = 1'b0;
    logic        fl_req;
    logic [39:0] fl_addr;
    logic        fl_inval;
    logic        fl_all;
    logic        fl_done = 1'b0;
    logic [39:0] lk_addr = '0;
    logic        lk_blocked;
    logic        st_valid;
    logic [15:0] st_num;
    logic        st_err;

    always #2 clk = ~clk;

    dflush_seq #(.NUM_RES(4), .EXT_OFS(EXT)) u0 (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_word(cmd_word), .cmd_ready(cmd_ready),
        .unblk_valid(unblk_valid), .unblk_whole(unblk_whole), .unblk_idx(unblk_idx),
        .unblk_num(unblk_num), .unblk_stat_req(unblk_stat_req), .unblk_ready(unblk_ready),
        .fwd_req(fwd_req), .fwd_addr(fwd_addr), .fwd_done(fwd_done),
        .fl_req(fl_req), .fl_addr(fl_addr), .fl_inval(fl_inval), .fl_all(fl_all),
        .fl_done(fl_done), .lk_addr(lk_addr), .lk_blocked(lk_blocked),
        .st_valid(st_valid), .st_num(st_num), .st_err(st_err)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // engine log
    int          nlog;
    int          log_typ [8];
    logic [39:0] log_addr[8];
    bit          log_inv [8];
    bit          log_all [8];
    int          log_cyc [8];
    int          st_seen, st_cyc, last_done;
    logic [15:0] st_num_r;
    bit          st_err_r, ready_c1;

    // bench model of resources
    bit          mbusy[4];
    logic [39:0] maddr[4];
    bit          mcache;

    task automatic chk(input string rq, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic run_seq(input string rq);
        bit pend = 1'b0;
        bit ended = 1'b0;
        nlog = 0; st_seen = 0; st_cyc = 0; last_done = 0; ready_c1 = 1'b1;
        for (int c = 1; c <= 100; c++) begin
            @(negedge clk);
            if (c == 1) ready_c1 = cmd_ready;
            if (st_valid) begin
                st_seen++; st_cyc = c; st_num_r = st_num; st_err_r = st_err;
            end
            if (pend) begin
                fwd_done = 1'b0; fl_done = 1'b0; pend = 1'b0;
            end else if (fwd_req || fl_req) begin
                if (nlog < 8) begin
                    log_typ[nlog]  = fwd_req ? 0 : 1;
                    log_addr[nlog] = fwd_req ? fwd_addr : fl_addr;
                    log_inv[nlog]  = fl_inval;
                    log_all[nlog]  = fl_all;
                    log_cyc[nlog]  = c;
                end
                nlog++;
                if (fwd_req) fwd_done = 1'b1; else fl_done = 1'b1;
                pend = 1'b1; last_done = c;
            end else if (cmd_ready) begin
                ended = 1'b1;
                break;
            end
        end
        if (!ended) chk(rq, "sequence end", 0, 1);
    endtask

    task automatic send_cmd(input logic [31:0] w0, input logic [31:0] w1, input logic [31:0] w2);
        logic [31:0] w[3];
        w[0] = w0; w[1] = w1; w[2] = w2;
        for (int b = 0; b < 3; b++) begin
            @(negedge clk);
            cmd_valid = 1'b1; cmd_word = w[b];
            #0.5;
            chk("R1", "cmd_ready in idle", cmd_ready, 1);
            @(posedge clk);
        end
        #1 cmd_valid = 1'b0;
    endtask

    task automatic do_cmd(input string rq, input logic [15:0] num, input bit stat, input logic [39:0] a,
                          input bit fwd, input bit rel, input logic [1:0] idx, input bit keep,
                          input bit blk, input bit all, input bit ext);
        bit exp_err;
        int exp_n;
        int k;
        logic [31:0] w2;
        w2 = {16'h0, ext, all, blk, keep, idx, rel, fwd, a[39:32]};
        if (all) exp_err = 1'b0;
        else if (rel && !mbusy[idx]) exp_err = 1'b1;
        else if (blk && mbusy[idx] && !rel) exp_err = 1'b1;
        else exp_err = 1'b0;
        send_cmd({15'h0, stat, num}, a[31:0], w2);
        run_seq(rq);
        chk("R1", "cmd_ready low after final beat", ready_c1, 0);
        if (exp_err) begin
            chk(rq, "no request on error", nlog, 0);
        end else if (all) begin
            chk("R7", "one whole flush", nlog, 1);
            chk("R7", "all flag", log_all[0], 1);
            chk("R7", "inval on whole", log_inv[0], 1);
            chk("R7", "flush type", log_typ[0], 1);
            mcache = 1'b1;
        end else begin
            exp_n = int'(fwd) + 1 + int'(ext);
            chk(rq, "request count", nlog, exp_n);
            chk(rq, "first request cycle", log_cyc[0], 2);
            k = 0;
            if (fwd) begin
                chk("R2", "forward first", log_typ[0], 0);
                chk("R2", "forward addr", log_addr[0], a);
                k = 1;
            end
            chk("R3", "flush type", log_typ[k], 1);
            chk("R3", "flush addr", log_addr[k], a);
            chk("R3", "inval flag", log_inv[k], !keep);
            chk("R3", "all flag low", log_all[k], 0);
            if (ext) begin
                chk("R4", "companion type", log_typ[k+1], 1);
                chk("R4", "companion addr", log_addr[k+1], a + EXT);
            end
            if (rel) mbusy[idx] = 1'b0;
            if (blk) begin mbusy[idx] = 1'b1; maddr[idx] = a; end
        end
        if (stat) begin
            chk("R10", "status count", st_seen, 1);
            chk("R10", "status num", st_num_r, num);
            chk("R10", "status err", st_err_r, exp_err);
            chk("R10", "status cycle", st_cyc, exp_err ? 2 : last_done + 1);
        end else begin
            chk("R10", "no status", st_seen, 0);
        end
    endtask

    task automatic do_unblk(input logic [15:0] num, input bit whole, input logic [1:0] idx);
        bit exp_err;
        exp_err = whole ? 1'b0 : !mbusy[idx];
        @(negedge clk);
        unblk_valid = 1'b1; unblk_whole = whole; unblk_idx = idx;
        unblk_num = num; unblk_stat_req = 1'b1;
        #0.5;
        chk("R9", "unblk_ready", unblk_ready, 1);
        @(posedge clk);
        #1 unblk_valid = 1'b0;
        run_seq("R9");
        chk("R9", "no request on unblock", nlog, 0);
        chk("R9", "unblock status err", st_err_r, exp_err);
        chk("R10", "unblock status num", st_num_r, num);
        chk("R10", "unblock status cycle", st_cyc, 1);
        if (whole) mcache = 1'b0; else mbusy[idx] = 1'b0;
    endtask

    task automatic look(input string rq, input logic [39:0] a, input bit exp);
        @(negedge clk);
        lk_addr = a;
        #0.5;
        chk(rq, "lookup", lk_blocked, exp);
    endtask

    function automatic logic [39:0] res_addr(input int i);
        return {8'h30 + 8'(i), 32'h0000_4000 * (i + 1)};
    endfunction

    initial begin
        for (int i = 0; i < 4; i++) begin mbusy[i] = 1'b0; maddr[i] = '0; end
        mcache = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        chk("R11", "cmd_ready", cmd_ready, 1);
        chk("R11", "unblk_ready", unblk_ready, 1);
        chk("R11", "fwd_req", fwd_req, 0);
        chk("R11", "fl_req", fl_req, 0);
        chk("R11", "st_valid", st_valid, 0);
        look("R11", 40'h0, 0);

        // sweep of forward / keep-valid / companion
        for (int k = 0; k < 8; k++) begin
            do_cmd("R3", 16'h100 + 16'(k), k[0] ^ k[2] ^ 1'b1,
                   {8'h10 + 8'(k), 32'hA000_0000 + 32'(k) * 32'h1000},
                   k[0], 1'b0, 2'(k), k[1], 1'b0, 1'b0, k[2]);
        end

        // R6: claim each resource, then look them up
        for (int i = 0; i < 4; i++)
            do_cmd("R6", 16'h200 + 16'(i), 1'b1, res_addr(i), 1'b0, 1'b0, 2'(i), 1'b0, 1'b1, 1'b0, 1'b0);
        for (int i = 0; i < 4; i++) begin
            look("R8", res_addr(i), 1);
            look("R8", res_addr(i) + 40'h1, 0);
        end

        // R6: reuse of busy resource without release
        do_cmd("R6", 16'h300, 1'b1, 40'h55_0000_0000, 1'b1, 1'b0, 2'd2, 1'b0, 1'b1, 1'b0, 1'b0);
        look("R6", res_addr(2), 1);
        look("R6", 40'h55_0000_0000, 0);

        // R5: release then reuse
        do_cmd("R5", 16'h301, 1'b1, 40'h66_0000_1000, 1'b1, 1'b1, 2'd1, 1'b0, 1'b1, 1'b0, 1'b1);
        look("R5", res_addr(1), 0);
        look("R5", 40'h66_0000_1000, 1);

        // R9: single unblock, then again on the free resource
        do_unblk(16'h400, 1'b0, 2'd3);
        look("R9", res_addr(3), 0);
        do_unblk(16'h401, 1'b0, 2'd3);

        // R5: release of a free resource aborts
        do_cmd("R5", 16'h302, 1'b1, 40'h12_3456_7890, 1'b1, 1'b1, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0);

        // R7: whole cache, other fields set but ignored
        do_cmd("R7", 16'h500, 1'b1, 40'h01_0000_0000, 1'b1, 1'b1, 2'd3, 1'b1, 1'b1, 1'b1, 1'b1);
        look("R7", 40'h77_1234_5678, 1);
        look("R7", res_addr(3), 1);
        do_unblk(16'h501, 1'b1, 2'd0);
        look("R9", 40'h77_1234_5678, 0);
        look("R7", res_addr(0), 1);
        look("R7", res_addr(3), 0);
        look("R7", 40'h66_0000_1000, 1);

        // R10: no status when not requested, on error and on success
        do_cmd("R10", 16'h600, 1'b0, 40'h12_0000_0000, 1'b0, 1'b1, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0);
        do_cmd("R10", 16'h601, 1'b0, 40'h13_0000_0040, 1'b1, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule